// File: doc/BRIEF.md
# Wormhole Switch Input Port

This block is the receiving side of one port of a packet-switched mesh router that forwards packets in wormhole fashion. A neighbouring switch offers flits one at a time over a two-phase handshake. The port answers only while its small flit FIFO has room, so each accepted flit costs two clock cycles on the link.

The first flit of a packet carries the destination. When it reaches the FIFO head, the port shows it on a dedicated output and raises a route request. An external routing and arbitration unit answers with a grant. After the grant the port streams the whole packet toward the reserved output over the same style of two-cycle handshake.

The second flit of every packet holds the number of payload flits that follow it. The port counts these flits down. When the final flit has been handed over, it pulses a release strobe for one cycle, which frees the path for the next packet. A stalled output keeps the flits in the FIFO and keeps the path held.

Top module: `wh_inport`

## Requirements
- R1: After reset the FIFO is empty and `up_ack`, `route_req`, `dn_tx` and `path_release` are all low.
- R2: When `up_tx` is high, `up_ack` is low and the FIFO holds fewer than 8 flits, `up_ack` goes high in the following cycle and `up_data` is stored. `up_ack` is never high unless `up_tx` was high in the cycle before.
- R3: While 8 flits are stored, a pending `up_tx` gets no `up_ack` and no flit is lost or overwritten.
- R4: Flits leave on `dn_data` in the order they were accepted, with unchanged values, the header flit first.
- R5: When a packet's first flit is at the FIFO head and no path is held, `route_req` rises with that flit on `hdr_flit`. `route_req` stays high until `route_grant` is seen.
- R6: `dn_tx` is never high before the packet's grant has been received.
- R7: The 16-bit value of a packet's second flit is the count N of flits after it, so the packet is 2+N flits long. `path_release` is high for exactly one cycle, in the cycle after the downstream handshake of the packet's last flit.
- R8: While `dn_tx` is high and `dn_ack` is low, `dn_tx` stays high and `dn_data` stays stable.
- R9: After a grant, `route_req` stays low until `path_release` has been high.
- R10: A packet whose length flit holds 0 consists of header and length flit only, and is released after the length flit.
- R11: In the cycle after a downstream handshake (`dn_tx` and `dn_ack` both high), `dn_tx` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_tx | input | 1 | Upstream sender offers a flit |
| up_data | input | 16 | Offered flit |
| up_ack | output | 1 | Flit accepted, one cycle after the offer |
| hdr_flit | output | 16 | Flit at the FIFO head, valid with route_req |
| route_req | output | 1 | Route request for the packet at the head |
| route_grant | input | 1 | Output path reserved for the request |
| dn_tx | output | 1 | Flit offered to the reserved output |
| dn_data | output | 16 | Offered flit toward the output |
| dn_ack | input | 1 | Output accepted the offered flit |
| path_release | output | 1 | One-cycle strobe after the packet's last flit |

## Verification
Two pairs of functions can fall in the same clock edge: an upstream write while the downstream side pops a flit, and the last-flit pop of one packet while the next header is already waiting in the FIFO. Random idle gaps on the sender and random stalls of the downstream acknowledge make both overlaps happen many times across forty packets. The FIFO contents are then judged by the exact order and values of the delivered flits. The request gating is judged by checking that no request appears between a grant and the following release strobe, and that every request presents the expected header.

// File: rtl/wh_inport.sv
module wh_inport #(
  parameter int FLIT_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_tx,
  input  logic [FLIT_W-1:0] up_data,
  output logic              up_ack,
  output logic [FLIT_W-1:0] hdr_flit,
  output logic              route_req,
  input  logic              route_grant,
  output logic              dn_tx,
  output logic [FLIT_W-1:0] dn_data,
  input  logic              dn_ack,
  output logic              path_release
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_SEND, S_REL} st_t;

  logic [FLIT_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     fill;
  logic              ack_q, tx_q;
  st_t               st;
  logic              hdr_gone, len_gone;
  logic [FLIT_W-1:0] remain;

  logic full, empty, wr_en, rd_en, last_pop;
  logic [FLIT_W-1:0] head;

  assign full     = (fill == CW'(DEPTH));
  assign empty    = (fill == '0);
  assign head     = mem[rd_ptr];
  assign wr_en    = up_tx && !ack_q && !full;
  assign rd_en    = tx_q && dn_ack;
  assign last_pop = rd_en && ((hdr_gone && !len_gone && head == '0) ||
                              (len_gone && remain == FLIT_W'(1)));

  assign up_ack       = ack_q;
  assign hdr_flit     = head;
  assign dn_data      = head;
  assign dn_tx        = tx_q;
  assign route_req    = (st == S_REQ);
  assign path_release = (st == S_REL);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= up_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= wr_en;
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      fill <= fill + CW'(wr_en) - CW'(rd_en);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tx_q     <= 1'b0;
      hdr_gone <= 1'b0;
      len_gone <= 1'b0;
      remain   <= '0;
    end else begin
      case (st)
        S_IDLE:  if (!empty) st <= S_REQ;
        S_REQ:   if (route_grant) st <= S_SEND;
        S_SEND:  if (last_pop) st <= S_REL;
        default: st <= S_IDLE;
      endcase

      if (rd_en)
        tx_q <= 1'b0;
      else if (st == S_SEND && !empty)
        tx_q <= 1'b1;

      if (last_pop) begin
        hdr_gone <= 1'b0;
        len_gone <= 1'b0;
        remain   <= '0;
      end else if (rd_en) begin
        if (!hdr_gone) begin
          hdr_gone <= 1'b1;
        end else if (!len_gone) begin
          len_gone <= 1'b1;
          remain   <= head;
        end else begin
          remain <= remain - FLIT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wh_inport_chk.sv
module wh_inport_chk #(
  parameter int FLIT_W = 16,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_tx,
  input logic              up_ack,
  input logic              route_req,
  input logic              route_grant,
  input logic              dn_tx,
  input logic              dn_ack,
  input logic [FLIT_W-1:0] dn_data,
  input logic              path_release
);
  int  occ;
  logic held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ  <= 0;
      held <= 1'b0;
    end else begin
      occ <= occ + (up_ack ? 1 : 0) - ((dn_tx && dn_ack) ? 1 : 0);
      if (route_req && route_grant) held <= 1'b1;
      else if (path_release)        held <= 1'b0;
    end
  end

  p_ack_after_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_ack) |-> $past(up_tx));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH && occ >= 0);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    route_req && !route_grant |=> route_req);
  p_no_send_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_tx |-> held);
  p_release_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    path_release |=> !path_release);
  p_stall_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_tx && !dn_ack |=> dn_tx && $stable(dn_data));
  p_no_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    route_req |-> !held);
  p_tx_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_tx && dn_ack |=> !dn_tx);
endmodule

bind wh_inport wh_inport_chk #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_tx(up_tx), .up_ack(up_ack),
  .route_req(route_req), .route_grant(route_grant), .dn_tx(dn_tx),
  .dn_ack(dn_ack), .dn_data(dn_data), .path_release(path_release)
);

// File: tb/tb_wh_inport.sv
module tb_wh_inport;
  localparam int NP = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_tx = 1'b0;
  logic [15:0] up_data = '0;
  logic up_ack, route_req, dn_tx, path_release;
  logic [15:0] hdr_flit, dn_data;
  logic grant_d = 1'b0;
  logic ack_d = 1'b0;

  always #2.5 clk = ~clk;

  wh_inport dut (
    .clk(clk), .rst_n(rst_n), .up_tx(up_tx), .up_data(up_data), .up_ack(up_ack),
    .hdr_flit(hdr_flit), .route_req(route_req), .route_grant(grant_d),
    .dn_tx(dn_tx), .dn_data(dn_data), .dn_ack(ack_d), .path_release(path_release)
  );

  logic [15:0] exp_f [0:511];
  bit          exp_last [0:511];
  int          exp_pkt [0:511];
  int          plen [0:NP-1];
  logic [15:0] exp_hdr [0:NP-1];
  int total = 0;
  int nchk = 0, nerr = 0;
  int cyc = 0, acks = 0, rels = 0, oi = 0, pk = 0;
  bit run = 0, held = 0, rel_exp = 0, rel_zero = 0, wait_prev = 0;
  logic [15:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int pick_len(input int p);
    if (p == 0) return 10;
    if (p == 1) return 0;
    return int'($urandom % 7);
  endfunction

  initial begin
    int seed_init;
    seed_init = int'($urandom(32'd7));
    for (int p = 0; p < NP; p++) begin
      plen[p] = pick_len(p);
      exp_hdr[p] = 16'($urandom);
      for (int k = 0; k < plen[p] + 2; k++) begin
        exp_f[total] = (k == 0) ? exp_hdr[p] : (k == 1) ? 16'(plen[p]) : 16'($urandom);
        exp_last[total] = (k == plen[p] + 1);
        exp_pkt[total] = p;
        total++;
      end
    end
  end

  always @(negedge clk) if (run) begin
    cyc++;
    if (up_ack) acks++;
    if (rel_exp || path_release)
      chk(path_release == rel_exp, rel_zero ? "R10" : "R7", int'(path_release), int'(rel_exp));
    if (path_release) begin held = 0; rels++; end
    rel_exp = 0;
    if (ack_d) begin
      ack_d = 0;
      chk(!dn_tx, "R11", int'(dn_tx), 0);
    end else begin
      if (wait_prev) chk(dn_tx && dn_data == prev_data, "R8", int'(dn_data), int'(prev_data));
      if (dn_tx) begin
        chk(held, "R6", int'(held), 1);
        if ($urandom % 3 != 0) begin
          chk(dn_data == exp_f[oi], "R4", int'(dn_data), int'(exp_f[oi]));
          rel_exp = exp_last[oi];
          rel_zero = (plen[exp_pkt[oi]] == 0);
          oi++;
          ack_d = 1;
          wait_prev = 0;
        end else begin
          wait_prev = 1;
          prev_data = dn_data;
        end
      end else wait_prev = 0;
    end
    if (grant_d) grant_d = 0;
    else if (route_req) begin
      chk(!held, "R9", int'(held), 0);
      if (cyc >= 80 && ($urandom % 2 == 1)) begin
        chk(hdr_flit == exp_hdr[pk], "R5", int'(hdr_flit), int'(exp_hdr[pk]));
        grant_d = 1;
        held = 1;
        pk++;
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    wait (run);
    @(negedge clk);
    for (int i = 0; i < total; i++) begin
      int w;
      repeat ($urandom % 3) @(negedge clk);
      up_tx = 1'b1;
      up_data = exp_f[i];
      w = 0;
      do begin @(negedge clk); w++; end while (!up_ack && w < 100000);
      if (i == 0) chk(w == 1, "R2", w, 1);
      up_tx = 1'b0;
      @(negedge clk);
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk(!up_ack && !route_req && !dn_tx && !path_release, "R1",
        {up_ack, route_req, dn_tx, path_release}, 0);
    run = 1;
    wait (cyc == 70);
    #0.1;
    chk(acks == 8 && up_tx && !up_ack, "R3", acks, 8);
    chk(route_req && hdr_flit == exp_hdr[0], "R5", int'(hdr_flit), int'(exp_hdr[0]));
    wait (oi == total || cyc >= 20000);
    repeat (5) @(negedge clk);
    if (cyc >= 20000) chk(0, "watchdog", cyc, 20000);
    chk(rels == NP, "R7", rels, NP);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule